// File: doc/BRIEF.md
# Misaligned Access Split-and-Merge Unit

This unit sits between a processor load/store port and a 32-bit, byte-addressable, word-wide memory. For each byte, halfword or word request it decides whether the address is naturally aligned for the access size. It then drives the memory with a word-aligned address and four byte-lane enables. An access that fits inside one memory word becomes one transaction, even when it is misaligned. An access that runs past the end of a word becomes two word transactions, and the bytes from both words are joined into one result.

On loads, the bytes are gathered in little-endian order and then sign-extended or zero-extended to 32 bits. On stores, each write enables only the lanes it needs, so no read-modify-write is required. A trap input changes how misaligned halfwords and words are handled: instead of being performed, they are answered at once with a fault flag.

The processor holds its request stable while `cpu_valid` is high. `cpu_ready` rises in the cycle the access completes, and read data and the fault flag are valid in that same cycle.

Top module: `misalign_split_unit`

## Requirements
- R1: An access of N bytes (size code 0 = byte, 1 = halfword, 2 or 3 = word) is misaligned when the address mod N is not zero. A byte access is never misaligned and never faults.
- R2: With `trap_en` = 1, a misaligned halfword or word request completes in its first cycle with `cpu_ready` = 1, `cpu_fault` = 1 and `cpu_rdata` = 0. No memory transaction is started, and memory is left unchanged.
- R3: Every memory transaction uses a word address whose two low bits are zero. The first transaction goes to the address with its two low bits cleared.
- R4: The byte enables are little-endian. Lane i carries the byte at word address + i. The first transaction enables lanes {N ones} shifted left by the address offset, keeping only lanes 0..3.
- R5: When offset + N ≤ 4, the access uses a single memory transaction. `cpu_ready` is high in the same cycle as that transaction's handshake.
- R6: When offset + N > 4 (and the access is not trapped), two transactions are made: the second goes to the next word address. `cpu_ready` stays low until the second one completes, so the access takes two cycles with a memory that is always ready.
- R7: The load result holds the memory bytes at address .. address+N-1 in bits [7:0] upward.
- R8: An unsigned load (`cpu_unsigned` = 1) zero-extends from bit 8N-1. A signed load copies bit 8N-1 into all higher bits.
- R9: A store writes exactly the bytes at address .. address+N-1, taken from `cpu_wdata` bits [7:0] upward. This holds for split stores as well, and no other byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_en | input | 1 | 1: misaligned halfword/word faults; 0: performed by splitting |
| cpu_valid | input | 1 | Request present, held stable until `cpu_ready` |
| cpu_ready | output | 1 | Access complete this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_unsigned | input | 1 | Zero-extend loads when 1 |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data, low bytes first |
| cpu_rdata | output | 32 | Extended load result |
| cpu_fault | output | 1 | Alignment fault, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts/completes the transaction |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Read word, valid with `mem_ready` |

## Verification
The only internal state is the phase bit and the captured first word. A phase left stuck in the second half shows up at the ports in the very next request: its address is off by four, or `cpu_ready` rises one cycle early or late. A wrong captured word shows up as wrong low bytes, but only on loads that cross a word boundary. The sweep therefore covers every size, offset, extension mode and trap setting against a byte-level memory model, and checks the cycle count, the first address and the lanes of every access.

// File: rtl/ual_pkg.sv
package ual_pkg;

    localparam int DW     = 32;
    localparam int LANES  = DW / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } size_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic              misaligned;
        logic              crosses;
        logic [LANES-1:0]  be_lo;
        logic [LANES-1:0]  be_hi;
        logic [DW-1:0]     wd_lo;
        logic [DW-1:0]     wd_hi;
    } lane_plan_t;

    function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] low_bits_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: low_bits_mask = 2'b00;
            SZ_HALF: low_bits_mask = 2'b01;
            default: low_bits_mask = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/ual_lane_map.sv
module ual_lane_map
    import ual_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [DW-1:0]    wdata,
    output lane_plan_t       plan
);
    logic [LANES-1:0]   mask;
    logic [2*LANES-1:0] be_wide;
    logic [DW-1:0]      wd_keep;
    logic [2*DW-1:0]    wd_wide;

    assign mask    = size_mask(size);
    assign be_wide = {{LANES{1'b0}}, mask} << off;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_keep
        assign wd_keep[8*g +: 8] = mask[g] ? wdata[8*g +: 8] : 8'h00;
    end

    assign wd_wide = {{DW{1'b0}}, wd_keep} << {off, 3'b000};

    always_comb begin
        plan.misaligned = (off & low_bits_mask(size)) != '0;
        plan.be_lo      = be_wide[LANES-1:0];
        plan.be_hi      = be_wide[2*LANES-1:LANES];
        plan.crosses    = |be_wide[2*LANES-1:LANES];
        plan.wd_lo      = wd_wide[DW-1:0];
        plan.wd_hi      = wd_wide[2*DW-1:DW];
    end

endmodule

// File: rtl/ual_load_merge.sv
module ual_load_merge
    import ual_pkg::*;
(
    input  logic [DW-1:0]    lo_word,
    input  logic [DW-1:0]    hi_word,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic             is_unsigned,
    output logic [DW-1:0]    result
);
    logic [2*DW-1:0] shifted;
    logic [DW-1:0]   raw;

    assign shifted = {hi_word, lo_word} >> {off, 3'b000};
    assign raw     = shifted[DW-1:0];

    always_comb begin
        case (size)
            SZ_BYTE: result = {{(DW-8){~is_unsigned & raw[7]}},   raw[7:0]};
            SZ_HALF: result = {{(DW-16){~is_unsigned & raw[15]}}, raw[15:0]};
            default: result = raw;
        endcase
    end

endmodule

// File: rtl/misalign_split_unit.sv
module misalign_split_unit
    import ual_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_en,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_unsigned,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_fault,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANES);

    phase_e            phase_q;
    logic [DW-1:0]     lo_q;
    lane_plan_t        plan;
    logic [ADDR_W-1:0] word_base;
    logic              trap_now;
    logic [DW-1:0]     merge_lo, merge_hi, merged;

    assign word_base = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign trap_now  = (phase_q == PH_FIRST) && cpu_valid && trap_en && plan.misaligned;
    assign mem_we    = cpu_we;

    ual_lane_map u_lane_map (
        .off   (cpu_addr[OFF_W-1:0]),
        .size  (cpu_size),
        .wdata (cpu_wdata),
        .plan  (plan)
    );

    always_comb begin
        mem_valid = 1'b0;
        mem_addr  = word_base;
        mem_be    = plan.be_lo;
        mem_wdata = plan.wd_lo;
        cpu_ready = 1'b0;
        cpu_fault = 1'b0;
        if (phase_q == PH_FIRST) begin
            if (trap_now) begin
                cpu_ready = 1'b1;
                cpu_fault = 1'b1;
            end else if (cpu_valid) begin
                mem_valid = 1'b1;
                cpu_ready = mem_ready && !plan.crosses;
            end
        end else begin
            mem_valid = 1'b1;
            mem_addr  = word_base + WORD_STEP;
            mem_be    = plan.be_hi;
            mem_wdata = plan.wd_hi;
            cpu_ready = mem_ready;
        end
    end

    assign merge_lo = (phase_q == PH_SECOND) ? lo_q      : mem_rdata;
    assign merge_hi = (phase_q == PH_SECOND) ? mem_rdata : '0;

    ual_load_merge u_merge (
        .lo_word     (merge_lo),
        .hi_word     (merge_hi),
        .off         (cpu_addr[OFF_W-1:0]),
        .size        (cpu_size),
        .is_unsigned (cpu_unsigned),
        .result      (merged)
    );

    assign cpu_rdata = cpu_fault ? '0 : merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FIRST;
            lo_q    <= '0;
        end else if (phase_q == PH_FIRST) begin
            if (cpu_valid && !trap_now && mem_ready && plan.crosses) begin
                phase_q <= PH_SECOND;
                lo_q    <= mem_rdata;
            end
        end else if (mem_ready) begin
            phase_q <= PH_FIRST;
        end
    end

    AST_MEM_WORD_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));                          // R3
    AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        cpu_fault |-> (cpu_ready && !mem_valid && cpu_rdata == '0));         // R2
    AST_BYTE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_size == 2'd0) |-> !cpu_fault);                      // R1
    AST_LANES_NONZERO: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_be != '0));                                        // R4
    AST_SPLIT_NEXT_WORD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !cpu_ready)
        |=> (mem_valid && !cpu_fault && mem_addr == $past(mem_addr) + WORD_STEP)); // R6

endmodule

// File: tb/test_misalign_split_unit.sv
`timescale 1ns/1ps
module test_misalign_split_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        trap_en;
    logic        cpu_valid;
    logic        cpu_ready;
    logic        cpu_we;
    logic [1:0]  cpu_size;
    logic        cpu_unsigned;
    logic [31:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic [31:0] cpu_rdata;
    logic        cpu_fault;
    logic        mem_valid;
    logic        mem_ready;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    logic [7:0]  mem   [0:15];
    logic [7:0]  image [0:15];
    int          n_checks = 0;
    int          n_fail   = 0;

    always #10 clk = ~clk;

    misalign_split_unit #(.ADDR_W(32)) i_misalign_split_unit (
        .clk, .rst, .trap_en, .cpu_valid, .cpu_ready, .cpu_we, .cpu_size,
        .cpu_unsigned, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_fault,
        .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata
    );

    always_comb begin
        for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] = mem[{mem_addr[3:2], 2'(k)}];
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[{mem_addr[3:2], 2'(k)}] <= mem_wdata[8*k +: 8];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 16; i++) begin
            mem[i]   = 8'(i * 8'h47 + 8'h3C);
            image[i] = 8'(i * 8'h47 + 8'h3C);
        end
    endtask

    task automatic run(input bit we, input logic [1:0] sz, input bit uns, input logic [3:0] ad,
                       input logic [31:0] wd, output logic [31:0] rd, output bit flt,
                       output int cyc, output logic [31:0] a0, output logic [3:0] be0);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_size = sz; cpu_unsigned = uns;
        cpu_addr = {28'd0, ad}; cpu_wdata = wd;
        cyc = 0; rd = '0; flt = 1'b0; a0 = '0; be0 = '0;
        forever begin
            cyc++;
            #2;
            if (cyc == 1) begin a0 = mem_addr; be0 = mem_be; end
            if (cpu_ready) begin rd = cpu_rdata; flt = cpu_fault; break; end
            if (cyc > 10) break;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rd, expv, a0, wd;
        logic [3:0]  be0;
        bit          flt, exp_flt;
        int          cyc, nb, off, exp_cyc, bad;

        rst = 1'b1; trap_en = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_size = 2'd0;
        cpu_unsigned = 1'b0; cpu_addr = '0; cpu_wdata = '0; mem_ready = 1'b1;
        init_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check(!cpu_ready && !mem_valid && !cpu_fault, "R5 idle after reset",
              {29'd0, cpu_ready, mem_valid, cpu_fault}, 32'd0);

        // Load sweep
        for (int tr = 0; tr < 2; tr++)
        for (int sz = 0; sz < 4; sz++)
        for (int ad = 0; ad < 8; ad++)
        for (int un = 0; un < 2; un++) begin
            trap_en = tr[0];
            init_mem();
            nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            off = ad % 4;
            exp_flt = tr[0] && (ad % nb != 0);
            exp_cyc = exp_flt ? 1 : ((off + nb > 4) ? 2 : 1);
            expv = '0;
            for (int k = 0; k < nb; k++) expv[8*k +: 8] = image[ad + k];
            if (un == 0 && expv[8*nb-1]) for (int b = 8*nb; b < 32; b++) expv[b] = 1'b1;
            if (exp_flt) expv = '0;
            run(1'b0, 2'(sz), un[0], 4'(ad), 32'h0, rd, flt, cyc, a0, be0);
            check(flt == exp_flt, "R1/R2 load fault flag", {31'd0, flt}, {31'd0, exp_flt});
            check(rd == expv, (un != 0) ? "R7/R8 load data unsigned" : "R7/R8 load data signed", rd, expv);
            check(cyc == exp_cyc, (exp_cyc == 2) ? "R6 split cycle count" : "R5 single cycle count",
                  32'(cyc), 32'(exp_cyc));
            if (!exp_flt) begin
                check(a0 == 32'(ad - off), "R3 first word address", a0, 32'(ad - off));
                check(be0 == 4'(((1 << nb) - 1) << off), "R4 first lane enables",
                      {28'd0, be0}, 32'(4'(((1 << nb) - 1) << off)));
            end
        end

        // Store sweep
        for (int tr = 0; tr < 2; tr++)
        for (int sz = 0; sz < 3; sz++)
        for (int ad = 0; ad < 8; ad++) begin
            trap_en = tr[0];
            init_mem();
            nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            off = ad % 4;
            wd  = 32'h9A3C_5E71 ^ (32'(ad) * 32'h0101_0101);
            exp_flt = tr[0] && (ad % nb != 0);
            if (!exp_flt) for (int k = 0; k < nb; k++) image[ad + k] = wd[8*k +: 8];
            run(1'b1, 2'(sz), 1'b0, 4'(ad), wd, rd, flt, cyc, a0, be0);
            bad = -1;
            for (int i = 0; i < 16; i++) if (bad < 0 && mem[i] !== image[i]) bad = i;
            check(bad < 0, exp_flt ? "R2 trapped store leaves memory" : "R9 store bytes",
                  (bad < 0) ? 32'd0 : {bad[7:0], 16'd0, mem[bad]},
                  (bad < 0) ? 32'd0 : {bad[7:0], 16'd0, image[bad]});
            check(flt == exp_flt, "R2 store fault flag", {31'd0, flt}, {31'd0, exp_flt});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule